// File: doc/BRIEF.md
# Audio Master Clock Ratio Generator

This block turns a fast audio reference clock into a master clock for an external converter at a chosen oversampling ratio. It also produces a strobe once per sample period. The reference runs at twice the source rate, 1024 or 768 times the sample rate fs. Because of that doubling, every master clock ratio, including the undivided source ratio, comes straight out of a register and never out of a combinational clock path.

A base-rate select bit picks one of two families: a 512x family or a 384x family. A 3-bit ratio code then halves the master clock once per step. The same code therefore gives a different ratio in each family. The base select, the ratio code and the run enable are sampled only at the end of a sample period. Output pulses therefore always have their full width. A combination that is not defined mutes the master clock and raises an error flag.

Top module: `mclk_ratio_gen`

## Requirements
- R1: While reset is held, and in the first cycle after reset, mclk_o, frame_stb_o and cfg_err_o are 0, and the active base is the 512x family.
- R2: With base_sel_i=0, code n (0..4) makes mclk_o a square wave of period 2^(n+1) clock cycles. This gives (512>>n)·fs for a clock of 1024·fs. The wave is low for the first half of each period, counted from the start of the sample period.
- R3: With base_sel_i=1, code n (0..3) makes mclk_o a square wave of period 2^(n+1) cycles. This gives (384>>n)·fs for a clock of 768·fs.
- R4: While running, frame_stb_o is high for exactly one cycle per sample period. A sample period lasts 1024 cycles in the 512x family and 768 cycles in the 384x family.
- R5: Once a sample period begins with run_i sampled at 0, mclk_o stays low and frame_stb_o stays 0.
- R6: base_sel_i, mult_code_i and run_i take effect only at the start of a sample period. Every high pulse of mclk_o lasts exactly half the period set by the code that was active when the pulse began.
- R7: Code 4 with base_sel_i=1, or any code from 5 to 7, is illegal. From the start of the next sample period, cfg_err_o is 1 and mclk_o is 0.
- R8: cfg_err_o returns to 0 at the first sample-period start at which a legal combination is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Doubled audio reference clock (1024·fs or 768·fs) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| base_sel_i | input | 1 | Family select: 0 = 512x, 1 = 384x |
| mult_code_i | input | 3 | Ratio code; each step halves the master clock |
| run_i | input | 1 | Enables the master clock and the strobe |
| mclk_o | output | 1 | Registered master clock |
| frame_stb_o | output | 1 | One-cycle pulse at each sample-period start |
| cfg_err_o | output | 1 | Active combination is illegal |

## Verification
All outputs are registered one cycle after the counter state that produces them. In the cycle after the last count of a sample period, the strobe is high, the new configuration's error flag is valid, and the master clock is low. The bench keeps its own period counter, advanced once per edge. It latches the inputs at that counter's wrap, the same cycle the block latches them, and compares all three outputs against it at every falling edge. Pulse widths are timed from each rising edge to the next falling edge of mclk_o. Strobe spacing is timed from one strobe to the next. Each width and spacing is checked at its closing edge against the configuration active when it began.

// File: rtl/mclkgen_pkg.sv
package mclkgen_pkg;

    localparam int CODE_W = 3;

    typedef struct packed {
        logic              base;
        logic [CODE_W-1:0] code;
        logic              run;
    } mcg_cfg_t;

    function automatic logic cfg_illegal(input mcg_cfg_t c, input int max_a, input int max_b);
        if (!c.base) return (int'(c.code) > max_a);
        return (int'(c.code) > max_b);
    endfunction

endpackage

// File: rtl/mcg_cfg_latch.sv
module mcg_cfg_latch
    import mclkgen_pkg::*;
#(
    parameter int MAX_CODE_A = 4,
    parameter int MAX_CODE_B = 3
) (
    input  logic     clk_i,
    input  logic     rst_ni,
    input  mcg_cfg_t req_i,
    input  logic     wrap_i,
    output mcg_cfg_t act_q_o,
    output mcg_cfg_t act_d_o,
    output logic     legal_d_o
);

    typedef struct packed {
        mcg_cfg_t act;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wrap_i) begin
            s_d.act = req_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign act_q_o   = s_q.act;
    assign act_d_o   = s_d.act;
    assign legal_d_o = !cfg_illegal(s_d.act, MAX_CODE_A, MAX_CODE_B);

endmodule

// File: rtl/mcg_phase_ctr.sv
module mcg_phase_ctr #(
    parameter int FRAME_A = 1024,
    parameter int FRAME_B = 768,
    parameter int PHASE_W = 10
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               base_q_i,
    output logic [PHASE_W-1:0] phase_q_o,
    output logic [PHASE_W-1:0] phase_d_o,
    output logic               wrap_o
);

    localparam logic [PHASE_W-1:0] TOP_A = PHASE_W'(FRAME_A - 1);
    localparam logic [PHASE_W-1:0] TOP_B = PHASE_W'(FRAME_B - 1);

    typedef struct packed {
        logic [PHASE_W-1:0] phase;
    } state_t;

    state_t s_d, s_q;
    logic   last;

    always_comb begin
        s_d  = s_q;
        last = (s_q.phase == (base_q_i ? TOP_B : TOP_A));
        if (last) begin
            s_d.phase = '0;
        end else begin
            s_d.phase = s_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase_q_o = s_q.phase;
    assign phase_d_o = s_d.phase;
    assign wrap_o    = last;

endmodule

// File: rtl/mcg_out_stage.sv
module mcg_out_stage
    import mclkgen_pkg::*;
#(
    parameter int PHASE_W = 10
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  mcg_cfg_t           act_d_i,
    input  logic               legal_d_i,
    input  logic [PHASE_W-1:0] phase_d_i,
    input  logic               wrap_i,
    output logic               mclk_o,
    output logic               stb_o,
    output logic               err_o
);

    typedef struct packed {
        logic mclk;
        logic stb;
        logic err;
    } state_t;

    state_t s_d, s_q;
    logic   sel_bit;

    always_comb begin
        sel_bit = 1'b0;
        for (int i = 0; i < PHASE_W; i++) begin
            if (int'(act_d_i.code) == i) sel_bit = phase_d_i[i];
        end
        s_d.mclk = act_d_i.run & legal_d_i & sel_bit;
        s_d.stb  = act_d_i.run & wrap_i;
        s_d.err  = ~legal_d_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mclk_o = s_q.mclk;
    assign stb_o  = s_q.stb;
    assign err_o  = s_q.err;

endmodule

// File: rtl/mclk_ratio_gen.sv
module mclk_ratio_gen
    import mclkgen_pkg::*;
#(
    parameter int FRAME_A    = 1024,
    parameter int FRAME_B    = 768,
    parameter int MAX_CODE_A = 4,
    parameter int MAX_CODE_B = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              base_sel_i,
    input  logic [CODE_W-1:0] mult_code_i,
    input  logic              run_i,
    output logic              mclk_o,
    output logic              frame_stb_o,
    output logic              cfg_err_o
);

    localparam int PHASE_W = $clog2(FRAME_A);

    mcg_cfg_t           req;
    mcg_cfg_t           act_q;
    mcg_cfg_t           act_d;
    logic               legal_d;
    logic [PHASE_W-1:0] phase_q;
    logic [PHASE_W-1:0] phase_d;
    logic               wrap;

    assign req.base = base_sel_i;
    assign req.code = mult_code_i;
    assign req.run  = run_i;

    mcg_phase_ctr #(
        .FRAME_A (FRAME_A),
        .FRAME_B (FRAME_B),
        .PHASE_W (PHASE_W)
    ) ctr_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .base_q_i  (act_q.base),
        .phase_q_o (phase_q),
        .phase_d_o (phase_d),
        .wrap_o    (wrap)
    );

    mcg_cfg_latch #(
        .MAX_CODE_A (MAX_CODE_A),
        .MAX_CODE_B (MAX_CODE_B)
    ) cfg_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .req_i     (req),
        .wrap_i    (wrap),
        .act_q_o   (act_q),
        .act_d_o   (act_d),
        .legal_d_o (legal_d)
    );

    mcg_out_stage #(
        .PHASE_W (PHASE_W)
    ) out_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .act_d_i   (act_d),
        .legal_d_i (legal_d),
        .phase_d_i (phase_d),
        .wrap_i    (wrap),
        .mclk_o    (mclk_o),
        .stb_o     (frame_stb_o),
        .err_o     (cfg_err_o)
    );

endmodule

// File: rtl/mcg_checker.sv
module mcg_checker
    import mclkgen_pkg::*;
#(
    parameter int PHASE_W = 10
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               mclk_o,
    input logic               frame_stb_o,
    input logic               cfg_err_o,
    input mcg_cfg_t           act_q,
    input logic [PHASE_W-1:0] phase_q,
    input logic               wrap
);

    // R7: an illegal active combination keeps the master clock low
    a_r7_err_mutes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_err_o |-> !mclk_o);

    // R5: with run inactive there is neither clock nor strobe
    a_r5_stopped_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !act_q.run |-> (!mclk_o && !frame_stb_o));

    // R6: the active configuration only moves at a sample-period wrap
    a_r6_cfg_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wrap |=> $stable(act_q));

    // R4: the strobe coincides with the first count of a sample period
    a_r4_stb_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_stb_o |-> (phase_q == '0));

    // R2: the master clock is low in the first count of every sample period
    a_r2_low_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_q == '0) |-> !mclk_o);

endmodule

bind mclk_ratio_gen mcg_checker #(.PHASE_W(PHASE_W)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mclk_o      (mclk_o),
    .frame_stb_o (frame_stb_o),
    .cfg_err_o   (cfg_err_o),
    .act_q       (act_q),
    .phase_q     (phase_q),
    .wrap        (wrap)
);

// File: tb/mclk_ratio_gen_tb_top.sv
`timescale 1ns/1ps
module mclk_ratio_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       base_sel = 1'b0;
    logic [2:0] code = 3'd0;
    logic       run = 1'b0;
    logic       mclk, stb, err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    mclk_ratio_gen dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .base_sel_i  (base_sel),
        .mult_code_i (code),
        .run_i       (run),
        .mclk_o      (mclk),
        .frame_stb_o (stb),
        .cfg_err_o   (err)
    );

    // bench model state
    int       m_phase = 0;
    bit       m_base = 0;
    int       m_code = 0;
    bit       m_run = 0;
    bit       m_mclk = 0, m_stb = 0, m_err = 0;
    // pulse and strobe spacing trackers
    bit       prev_mclk = 0;
    int       hi_len = 0, hi_exp = 0;
    bit       seen_stb = 0;
    int       since_stb = 0, frame_exp = 0;

    function automatic bit exp_illegal(bit b, int c);
        return b ? (c > 3) : (c > 4);
    endfunction

    function automatic int exp_frame(bit b);
        return b ? 768 : 1024;
    endfunction

    task automatic chk(string req, int act, int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    task automatic advance_model();
        bit wrapped;
        wrapped = (m_phase == exp_frame(m_base) - 1);
        if (wrapped) begin
            m_phase = 0;
            m_base  = base_sel;
            m_code  = int'(code);
            m_run   = run;
        end else begin
            m_phase++;
        end
        m_err  = exp_illegal(m_base, m_code);
        m_mclk = m_run && !m_err && (((m_phase >> m_code) & 1) == 1);
        m_stb  = m_run && wrapped;
    endtask

    task automatic check_cycle();
        string mtag;
        mtag = !m_run ? "R5" : (m_base ? "R3" : "R2");
        chk(mtag, int'(mclk), int'(m_mclk));
        chk("R4", int'(stb), int'(m_stb));
        chk(m_err ? "R7" : "R8", int'(err), int'(m_err));
        // R6: high pulse width
        if (mclk && !prev_mclk) begin
            hi_len = 1;
            hi_exp = 1 << m_code;
        end else if (mclk) begin
            hi_len++;
        end else if (prev_mclk) begin
            chk("R6", hi_len, hi_exp);
        end
        prev_mclk = mclk;
        // R4: strobe spacing
        if (!m_run) seen_stb = 0;
        if (stb) begin
            if (seen_stb) chk("R4", since_stb, frame_exp);
            seen_stb  = 1;
            since_stb = 0;
            frame_exp = exp_frame(m_base);
        end
        since_stb++;
    endtask

    task automatic run_cycles(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_cycle();
            advance_model();
        end
    endtask

    task automatic set_cfg(bit b, int c, bit r);
        base_sel = b;
        code     = 3'(c);
        run      = r;
    endtask

    initial begin
        #(8ns * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        // R1: reset state, with inputs requesting a running 384x clock
        set_cfg(1, 0, 1);
        repeat (3) @(negedge clk);
        chk("R1", int'(mclk), 0);
        chk("R1", int'(stb), 0);
        chk("R1", int'(err), 0);
        rst_n = 1'b1;
        advance_model();
        @(negedge clk);
        chk("R1", int'(mclk), 0);
        chk("R1", int'(stb), 0);
        // R1: default base is 512x, so the first period lasts 1024 cycles
        chk("R1", m_phase, 1);
        check_cycle();
        advance_model();
        run_cycles(1100);

        // R2: every 512x code
        for (int c = 0; c <= 4; c++) begin
            set_cfg(0, c, 1);
            run_cycles(2100);
        end
        // R3: every 384x code
        for (int c = 0; c <= 3; c++) begin
            set_cfg(1, c, 1);
            run_cycles(1600);
        end
        // R7: illegal combos, R8: recovery
        set_cfg(1, 4, 1);
        run_cycles(1600);
        set_cfg(0, 6, 1);
        run_cycles(1600);
        set_cfg(0, 2, 1);
        run_cycles(2100);
        // R5: stop and restart
        set_cfg(0, 1, 0);
        run_cycles(2100);
        set_cfg(1, 1, 1);
        run_cycles(1600);

        // R6: random changes at random points inside sample periods
        for (int k = 0; k < 50; k++) begin
            int c;
            c = ($urandom_range(0, 9) < 8) ? int'($urandom_range(0, 4)) : int'($urandom_range(5, 7));
            set_cfg(1'($urandom_range(0, 1)), c, ($urandom_range(0, 9) < 8));
            run_cycles(int'($urandom_range(50, 1500)));
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule